// File: doc/BRIEF.md
# Multichannel Parallel ADC Read Sequencer

This block is the host-side controller for an 8-bit, 8-channel converter with a parallel output bus. The converter is controlled by only two active-low strobes, chip select and read. Pulling both strobes low starts a conversion on the channel on the 3-bit address lines. The sequencer scans the channels set in an enable mask in ascending order. It drives the address and the two strobes, and it returns each result on a valid/ready stream together with the channel the result belongs to.

The sequencer has two read disciplines. In stalling mode the strobes stay low until the conversion finishes, so the captured byte belongs to the channel addressed in that same read. In pipelined mode each short read starts a new conversion and returns the result of the previous one. The sequencer therefore tags each byte with the channel of the previous read, drops the first read of a scan and adds one flush read after the last channel.

For bipolar inputs an optional formatter converts complementary offset binary to two's complement. A scan runs once per start pulse, or repeats for as long as the continuous control is held.

Top module: `adc_scan_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, adc_cs_no and adc_rd_no are high and out_valid_o is low. Asserting reset during a read raises both strobes at once.
- R2: A start_i pulse in idle reads every channel whose chan_en_i bit is set, once, in ascending index order. The address driven is the channel index in plain binary (0 selects the first input, 7 the last). A start with an all-zero mask issues no read.
- R3: adc_cs_no and adc_rd_no fall and rise together, and adc_addr_o holds steady for the whole time they are low.
- R4: With mode_i=0 latched at start, each read holds the strobes low for CONV_CYCLES cycles (or until conv_done_i is high when USE_DONE=1). The byte captured at that point is emitted tagged with the channel addressed in the same read.
- R5: With mode_i=1 latched at start, each read holds the strobes low for ACC_CYCLES cycles. The byte is tagged with the channel of the previous read. The first read of a scan is dropped, and one extra read follows the last enabled channel, so a scan of N channels makes N+1 reads and N outputs.
- R6: Between the end of one read and the start of the next, the strobes stay high for at least MIN_HIGH cycles.
- R7: out_chan_o and out_data_o stay stable while out_valid_o is high and out_ready_i is low. No new read starts while a result waits to be taken.
- R8: With bipolar_i=1 latched at start, the output byte is the raw byte with bits 6..0 inverted and bit 7 kept (0x80 becomes 0xFF). With bipolar_i=0 the raw byte is passed unchanged.
- R9: When a scan ends with cont_i high, a new scan starts from the lowest enabled channel. When it ends with cont_i low, the sequencer goes idle and makes no further reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a scan when idle |
| cont_i | input | 1 | Repeat scans while high |
| mode_i | input | 1 | 0 stalling read, 1 pipelined read |
| bipolar_i | input | 1 | Convert results to two's complement |
| chan_en_i | input | 8 | Channel enable mask, bit i enables channel i |
| conv_done_i | input | 1 | Conversion complete from converter (used when USE_DONE=1) |
| adc_data_i | input | 8 | Converter data bus |
| adc_cs_no | output | 1 | Converter chip select, active low |
| adc_rd_no | output | 1 | Converter read strobe, active low |
| adc_addr_o | output | 3 | Converter channel address |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result accepted |
| out_chan_o | output | 3 | Channel the result belongs to |
| out_data_o | output | 8 | Result byte |

## Verification
The bench builds the sequencer with CONV_CYCLES=5, ACC_CYCLES=2, MIN_HIGH=3 and USE_DONE=0. These short windows let the bench measure every strobe low time and high gap exactly, and keep full-mask scans in both modes to a few hundred cycles. A converter model returns a byte derived from the channel of either the current read or the previous one. A wrong channel tag, a missing flush read or a missing discarded read therefore shows up as a wrong byte or a wrong read count. The conv_done_i completion path is not selected with these values and is left to an integration bench.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_GAP,
    S_STROBE,
    S_OUT
  } seq_state_e;
endpackage

// File: rtl/adc_scan_pick.sv
// Lowest enabled channel at or above from_i.
module adc_scan_pick #(
  parameter int NCH = 8,
  parameter int AW  = 3
) (
  input  logic [NCH-1:0] mask_i,
  input  logic [AW:0]    from_i,
  output logic           found_o,
  output logic [AW-1:0]  idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i] && ((AW+1)'(i) >= from_i)) begin
        found_o = 1'b1;
        idx_o   = AW'(i);
      end
    end
  end
endmodule

// File: rtl/adc_scan_fmt.sv
// Complementary offset binary to two's complement: keep MSB, invert the rest.
module adc_scan_fmt #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] raw_i,
  input  logic          bipolar_i,
  output logic [DW-1:0] data_o
);
  assign data_o = bipolar_i ? {raw_i[DW-1], ~raw_i[DW-2:0]} : raw_i;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int DW          = 8,
  parameter int CONV_CYCLES = 6,
  parameter int ACC_CYCLES  = 2,
  parameter int MIN_HIGH    = 3,
  parameter bit USE_DONE    = 1'b0,
  localparam int AW         = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           cont_i,
  input  logic           mode_i,
  input  logic           bipolar_i,
  input  logic [NCH-1:0] chan_en_i,
  input  logic           conv_done_i,
  input  logic [DW-1:0]  adc_data_i,
  output logic           adc_cs_no,
  output logic           adc_rd_no,
  output logic [AW-1:0]  adc_addr_o,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [AW-1:0]  out_chan_o,
  output logic [DW-1:0]  out_data_o
);
  localparam int MAXC = (CONV_CYCLES > ACC_CYCLES)
                        ? ((CONV_CYCLES > MIN_HIGH) ? CONV_CYCLES : MIN_HIGH)
                        : ((ACC_CYCLES > MIN_HIGH) ? ACC_CYCLES : MIN_HIGH);
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic [NCH-1:0] mask_q;
  logic           mode_q, bip_q, first_q, flush_q, last_q;
  logic [AW-1:0]  cur_q, prev_q, res_chan_q;
  logic [DW-1:0]  res_raw_q;

  logic           first_found, next_found;
  logic [AW-1:0]  first_idx, next_idx;
  logic [NCH-1:0] first_mask;
  logic [AW:0]    next_from;

  assign first_mask = (state_q == S_IDLE) ? chan_en_i : mask_q;
  assign next_from  = {1'b0, cur_q} + (AW+1)'(1);

  adc_scan_pick #(.NCH(NCH), .AW(AW)) u_pick_first (
    .mask_i (first_mask),
    .from_i ('0),
    .found_o(first_found),
    .idx_o  (first_idx)
  );

  adc_scan_pick #(.NCH(NCH), .AW(AW)) u_pick_next (
    .mask_i (mask_q),
    .from_i (next_from),
    .found_o(next_found),
    .idx_o  (next_idx)
  );

  adc_scan_fmt #(.DW(DW)) u_fmt (
    .raw_i    (res_raw_q),
    .bipolar_i(bip_q),
    .data_o   (out_data_o)
  );

  logic stall_end, conv_end, emit, end_scan;
  assign stall_end = USE_DONE ? conv_done_i : (cnt_q == CW'(CONV_CYCLES - 1));
  assign conv_end  = mode_q ? (cnt_q == CW'(ACC_CYCLES - 1)) : stall_end;
  assign emit      = !mode_q || !first_q;           // pipelined: first read is stale
  assign end_scan  = mode_q ? flush_q : !next_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      mask_q     <= '0;
      mode_q     <= 1'b0;
      bip_q      <= 1'b0;
      first_q    <= 1'b0;
      flush_q    <= 1'b0;
      last_q     <= 1'b0;
      cur_q      <= '0;
      prev_q     <= '0;
      res_chan_q <= '0;
      res_raw_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (start_i && first_found) begin
            mask_q  <= chan_en_i;
            mode_q  <= mode_i;
            bip_q   <= bipolar_i;
            cur_q   <= first_idx;
            first_q <= 1'b1;
            flush_q <= 1'b0;
            cnt_q   <= '0;
            state_q <= S_GAP;
          end
        end
        S_GAP: begin
          if (cnt_q == CW'(MIN_HIGH - 1)) begin
            cnt_q   <= '0;
            state_q <= S_STROBE;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        S_STROBE: begin
          if (conv_end) begin
            cnt_q   <= '0;
            prev_q  <= cur_q;
            first_q <= 1'b0;
            if (mode_q && !flush_q && !next_found) flush_q <= 1'b1;  // re-read last channel to flush
            else if (next_found && !flush_q)       cur_q   <= next_idx;
            if (emit) begin
              res_chan_q <= mode_q ? prev_q : cur_q;
              res_raw_q  <= adc_data_i;
              last_q     <= end_scan;
              state_q    <= S_OUT;
            end else begin
              state_q <= S_GAP;
            end
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        S_OUT: begin
          if (out_ready_i) begin
            cnt_q <= '0;
            if (!last_q) begin
              state_q <= S_GAP;
            end else if (cont_i && first_found) begin
              cur_q   <= first_idx;
              first_q <= 1'b1;
              flush_q <= 1'b0;
              state_q <= S_GAP;
            end else begin
              state_q <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign adc_cs_no   = (state_q != S_STROBE);
  assign adc_rd_no   = (state_q != S_STROBE);
  assign adc_addr_o  = cur_q;
  assign out_valid_o = (state_q == S_OUT);
  assign out_chan_o  = res_chan_q;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int AW       = 3,
  parameter int DW       = 8,
  parameter int MIN_HIGH = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          adc_cs_no,
  input logic          adc_rd_no,
  input logic [AW-1:0] adc_addr_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [AW-1:0] out_chan_o,
  input logic [DW-1:0] out_data_o
);
  localparam int HW = $clog2(MIN_HIGH + 1) + 1;
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hi_q <= '0;
    else if (!adc_cs_no)             hi_q <= '0;
    else if (hi_q < HW'(MIN_HIGH))   hi_q <= hi_q + HW'(1);
  end

  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_cs_no && !adc_rd_no) |=> (adc_cs_no || $stable(adc_addr_o)));

  assert_min_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_cs_no) |-> (hi_q >= HW'(MIN_HIGH)));

  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_chan_o) && $stable(out_data_o)));

  assert_no_read_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (adc_cs_no && adc_rd_no));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.AW(AW), .DW(DW), .MIN_HIGH(MIN_HIGH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .adc_cs_no  (adc_cs_no),
  .adc_rd_no  (adc_rd_no),
  .adc_addr_o (adc_addr_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_chan_o (out_chan_o),
  .out_data_o (out_data_o)
);

// File: tb/adc_scan_seq_tb_top.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;
  localparam int CONV = 5;
  localparam int ACC  = 2;
  localparam int MINH = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, cont = 1'b0, mode = 1'b0, bip = 1'b0;
  logic [7:0] chan_en = '0;
  logic       done = 1'b0;
  logic [7:0] adc_data;
  logic       cs_n, rd_n;
  logic [2:0] addr;
  logic       valid;
  logic       ready = 1'b1;
  logic [2:0] ochan;
  logic [7:0] odata;

  always #2.5 clk = ~clk;

  adc_scan_seq #(
    .CONV_CYCLES(CONV), .ACC_CYCLES(ACC), .MIN_HIGH(MINH), .USE_DONE(1'b0)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont), .mode_i(mode),
    .bipolar_i(bip), .chan_en_i(chan_en), .conv_done_i(done), .adc_data_i(adc_data),
    .adc_cs_no(cs_n), .adc_rd_no(rd_n), .adc_addr_o(addr), .out_valid_o(valid),
    .out_ready_i(ready), .out_chan_o(ochan), .out_data_o(odata)
  );

  int n_chk = 0, n_err = 0;
  int reads = 0, nrec = 0, rcnt = 0, gap = 100, low_len = 0;
  logic [2:0] rec_chan [64];
  logic [7:0] rec_data [64];
  logic stall = 1'b0, cur_mode = 1'b0, strobe_q = 1'b0, pend_q = 1'b0;
  logic [2:0] cur_addr = '0, last_conv = '0, pend_c = '0;
  logic [7:0] pend_d = '0;

  function automatic logic [7:0] fconv(input logic [2:0] c);
    return 8'h80 + 8'h11 * {5'd0, c};
  endfunction

  // Converter model: stalling returns this read's channel, pipelined the previous read's.
  assign adc_data = cur_mode ? fconv(last_conv) : fconv(cur_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      strobe_q = 1'b0; gap = 100; pend_q = 1'b0;
    end else begin
      logic strobe, rdy_n;
      strobe = !cs_n && !rd_n;
      if (strobe && !strobe_q) begin
        reads++;
        cur_addr = addr;
        chk(gap >= MINH, "R6 high gap", gap, MINH);
        chk(cs_n == rd_n, "R3 strobe pair", int'(cs_n), int'(rd_n));
        low_len = 1;
      end else if (strobe) begin
        low_len++;
        if (addr != cur_addr) chk(1'b0, "R3 addr hold", addr, cur_addr);
      end
      if (!strobe && strobe_q) begin
        last_conv = cur_addr;
        chk(cs_n == rd_n, "R3 strobe pair", int'(cs_n), int'(rd_n));
        if (cur_mode) chk(low_len == ACC, "R5 low time", low_len, ACC);
        else          chk(low_len == CONV, "R4 low time", low_len, CONV);
        gap = 1;
      end else if (!strobe && gap < 100) begin
        gap++;
      end
      strobe_q = strobe;
      if (pend_q) chk(valid && ochan == pend_c && odata == pend_d, "R7 hold", odata, pend_d);
      rdy_n = stall ? (rcnt % 3 == 0) : 1'b1;
      rcnt++;
      if (valid && !rdy_n) begin
        pend_q = 1'b1; pend_c = ochan; pend_d = odata;
      end else begin
        pend_q = 1'b0;
      end
      if (valid && rdy_n && nrec < 64) begin
        rec_chan[nrec] = ochan; rec_data[nrec] = odata; nrec++;
      end
      ready = rdy_n;
    end
  end

  // {stall, bipolar, mode, mask}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 8'hFF},
    {1'b0, 1'b0, 1'b1, 8'hFF},
    {1'b0, 1'b1, 1'b0, 8'h81},
    {1'b1, 1'b1, 1'b1, 8'h24},
    {1'b0, 1'b0, 1'b1, 8'h80},
    {1'b1, 1'b0, 1'b0, 8'h01},
    {1'b0, 1'b0, 1'b1, 8'h01},
    {1'b0, 1'b0, 1'b0, 8'h00}
  };

  task automatic run_scan(input logic md, input logic [7:0] msk, input logic bp, input logic stl);
    int n, k;
    logic [7:0] raw, exp_d;
    @(negedge clk);
    mode = md; chan_en = msk; bip = bp; stall = stl; cur_mode = md;
    nrec = 0; reads = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = $countones(msk);
    for (int t = 0; t < 3000 && nrec < n; t++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(nrec == n, "R2 output count", nrec, n);
    if (md) chk(reads == n + 1, "R5 read count", reads, n + 1);
    else    chk(reads == n, "R2 read count", reads, n);
    k = 0;
    for (int i = 0; i < 8; i++) begin
      if (msk[i] && k < nrec) begin
        raw   = fconv(3'(i));
        exp_d = bp ? {raw[7], ~raw[6:0]} : raw;
        chk(rec_chan[k] == 3'(i), md ? "R5 channel tag" : "R4 channel tag", rec_chan[k], i);
        chk(rec_data[k] == exp_d, bp ? "R8 data" : (md ? "R5 data" : "R4 data"), rec_data[k], exp_d);
        k++;
      end
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    chk(cs_n && rd_n && !valid, "R1 in reset", {cs_n, rd_n, valid}, 3'b110);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(cs_n && rd_n && !valid && reads == 0, "R1 idle after reset", reads, 0);

    for (int v = 0; v < 8; v++)
      run_scan(VEC[v][8], VEC[v][7:0], VEC[v][9], VEC[v][10]);

    // R9 continuous scanning, then stop at scan end
    @(negedge clk);
    mode = 1'b0; chan_en = 8'h12; bip = 1'b0; stall = 1'b0; cur_mode = 1'b0;
    nrec = 0; reads = 0; cont = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 3000 && nrec < 5; t++) @(negedge clk);
    cont = 1'b0;
    for (int t = 0; t < 3000 && nrec < 6; t++) @(negedge clk);
    repeat (40) @(negedge clk);
    r0 = reads;
    repeat (40) @(negedge clk);
    chk(reads == r0, "R9 stops after scan", reads, r0);
    chk(nrec == 6, "R9 output count", nrec, 6);
    for (int k = 0; k < 6 && k < nrec; k++)
      chk(rec_chan[k] == ((k % 2 == 0) ? 3'd1 : 3'd4), "R9 wrap order", rec_chan[k], (k % 2 == 0) ? 1 : 4);

    // R1 reset during a read
    @(negedge clk);
    chan_en = 8'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 100 && cs_n; t++) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(cs_n && rd_n && !valid, "R1 reset mid read", {cs_n, rd_n, valid}, 3'b110);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    r0 = reads;
    repeat (30) @(negedge clk);
    chk(reads == r0 && cs_n, "R1 idle after mid reset", reads, r0);

    finish_run();
  end
endmodule